// File: doc/BRIEF.md
# Audio Serial Link Frame Engine (Codec Side)

This block sits at the codec end of a five-wire, time-division multiplexed audio link. It runs from the link bit clock and keeps track of where each bit falls inside a 256-bit frame. The controller marks the start of each frame with a sync pulse. The engine cuts the incoming serial stream into one 16-bit tag slot and twelve 20-bit slots. For each completed slot it presents a parallel word and raises a one-hot strobe for that slot.

In the other direction, the engine takes a parallel snapshot of a ready flag, twelve slot-valid flags and twelve 20-bit payload words. It sends these back as a frame with the same layout. The tag for that frame is built from the flags. Slots not marked valid are sent as zeros.

All serial captures, and the frame-position counter, use the falling edge of the bit clock. The outgoing line changes only on rising edges. If a sync pulse arrives at an unexpected position, the engine realigns to it and flags a framing error.

Top module: `aclk_frame_engine`

## Requirements
- R1: While reset is held, and afterwards until the first rising edge of `frame_sync` is sampled, `rx_strobe`, `frame_start`, `frame_err` and `link_tx` stay low. The first sync seen after reset never raises `frame_err`.
- R2: `frame_sync` is sampled on falling edges. The falling edge that first sees it high captures frame bit 255 of the previous frame. `frame_start` is high for exactly the bit period after that edge.
- R3: Bits arrive most-significant first. Frame positions 0..15 form slot 0, and its word appears in `rx_word[15:0]` with `rx_word[19:16]` zero. Slot k (1..12) occupies positions 16+20(k-1) through 35+20(k-1), and its word fills all 20 bits of `rx_word`.
- R4: When the last bit of slot s is captured, `rx_strobe[s]` goes high for one bit period. In that same period `rx_slot` equals s and `rx_word` holds the slot's word.
- R5: The slot 0 strobe always fires. The strobe for slot s (1..12) fires only when, in the tag captured earlier in the same frame, bit 15 (frame valid) is set and bit 15-s (slot s valid) is set.
- R6: The outgoing tag carries `codec_ready` in bit 15 and `tx_slot_valid[k-1]` in bit 15-k for slot k = 1..12. Bits 2..0 are zero.
- R7: Outgoing slots use the same positions and most-significant-first order as incoming ones. A slot whose valid flag is clear is sent as zeros. The inputs are sampled on the falling edge that detects sync. Bit 0 of the frame is driven on the rising edge that follows, and each later bit on each later rising edge.
- R8: If a sync edge arrives when the captured bit would not have been position 255, three things happen: `frame_err` pulses together with `frame_start`, the next captured bit is treated as position 0, and no slot strobe fires on that edge.
- R9: At most one bit of `rx_strobe` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Frame sync pulse from the controller |
| link_rx | input | 1 | Serial data from controller to codec |
| codec_ready | input | 1 | Ready flag placed in outgoing tag bit 15 |
| tx_slot_valid | input | 12 | Bit k-1 marks outgoing slot k valid |
| tx_payload | input | 240 | Outgoing slot k word at bits [20(k-1) +: 20] |
| link_tx | output | 1 | Serial data from codec to controller |
| rx_word | output | 20 | Word of the most recently completed slot |
| rx_slot | output | 4 | Index of the most recently completed slot |
| rx_strobe | output | 13 | One-hot slot-complete strobe, bit s for slot s |
| frame_start | output | 1 | One-bit pulse after sync detection |
| frame_err | output | 1 | One-bit pulse when sync arrives misaligned |

## Verification
Two functions can land on the same falling edge: a sync-driven realignment and the completion of a slot. In normal framing this happens every frame, because the sync edge captures the last bit of slot 12, and that strobe must still fire. The bench also raises sync early, at position 95, which is where slot 4 ends, with slot 4 marked valid. That edge must give `frame_start` and `frame_err` together with no strobe. The frame that follows must then be captured and transmitted in correct alignment.

// File: rtl/aclk_frame_pkg.sv
package aclk_frame_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int DATA_SLOTS = 12;
  localparam int NUM_SLOTS  = DATA_SLOTS + 1;
  localparam int FRAME_BITS = TAG_BITS + DATA_SLOTS * SLOT_BITS;
  localparam int PAY_BITS   = DATA_SLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);

  typedef logic [POS_W-1:0] pos_t;

  // Position following p, wrapping at the frame length.
  function automatic pos_t pos_next(pos_t p);
    return (int'(p) == FRAME_BITS - 1) ? '0 : p + pos_t'(1);
  endfunction

  // Slot index containing frame position p.
  function automatic int unsigned slot_of(pos_t p);
    if (int'(p) < TAG_BITS) return 0;
    return (int'(p) - TAG_BITS) / SLOT_BITS + 1;
  endfunction

  // True when p is the final bit of its slot.
  function automatic logic is_slot_end(pos_t p);
    if (int'(p) < TAG_BITS) return int'(p) == TAG_BITS - 1;
    return ((int'(p) - TAG_BITS) % SLOT_BITS) == SLOT_BITS - 1;
  endfunction

  // Frame position of the final bit of slot s.
  function automatic pos_t slot_end_pos(int unsigned s);
    if (s == 0) return pos_t'(TAG_BITS - 1);
    return pos_t'(TAG_BITS - 1 + SLOT_BITS * int'(s));
  endfunction

  // Frame image, frame position p at index FRAME_BITS-1-p.
  function automatic logic [FRAME_BITS-1:0] pack_frame(
    logic [TAG_BITS-1:0] tag, logic [PAY_BITS-1:0] pay);
    logic [FRAME_BITS-1:0] img;
    img[FRAME_BITS-1 -: TAG_BITS] = tag;
    for (int k = 0; k < DATA_SLOTS; k++)
      img[FRAME_BITS-1-TAG_BITS-k*SLOT_BITS -: SLOT_BITS] = pay[k*SLOT_BITS +: SLOT_BITS];
    return img;
  endfunction
endpackage

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer
  import aclk_frame_pkg::*;
(
  input  logic bclk,
  input  logic rst_n,
  input  logic frame_sync,
  output pos_t cap_pos,
  output logic sync_edge,
  output logic misalign,
  output pos_t bit_pos,
  output logic locked,
  output logic frame_start,
  output logic frame_err
);
  logic sync_q;
  pos_t pos_inc;

  assign pos_inc   = pos_next(bit_pos);
  assign sync_edge = frame_sync & ~sync_q;
  // Bit taken on a sync edge closes the previous frame.
  assign cap_pos   = sync_edge ? pos_t'(FRAME_BITS - 1) : pos_inc;
  assign misalign  = sync_edge & locked & (pos_inc != pos_t'(FRAME_BITS - 1));

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      bit_pos     <= '0;
      locked      <= 1'b0;
      frame_start <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      sync_q      <= frame_sync;
      bit_pos     <= cap_pos;
      frame_start <= sync_edge;
      frame_err   <= misalign;
      if (sync_edge) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/aclk_rx_deser.sv
module aclk_rx_deser
  import aclk_frame_pkg::*;
(
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic                  link_rx,
  input  logic                  locked,
  input  logic                  misalign,
  input  pos_t                  cap_pos,
  output logic [SLOT_BITS-1:0]  rx_word,
  output logic [SLOT_IDX_W-1:0] rx_slot,
  output logic [NUM_SLOTS-1:0]  rx_strobe
);
  logic [SLOT_BITS-1:0]  shreg, shift_nx;
  logic [TAG_BITS-1:0]   tag_q;
  logic                  slot_end;
  logic [SLOT_IDX_W-1:0] slot_nx;
  logic [NUM_SLOTS-1:0]  strobe_nx;

  assign shift_nx = {shreg[SLOT_BITS-2:0], link_rx};
  assign slot_end = locked & ~misalign & is_slot_end(cap_pos);
  assign slot_nx  = SLOT_IDX_W'(slot_of(cap_pos));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_gate
    if (s == 0) begin : g_tag
      assign strobe_nx[s] = slot_end && (slot_nx == SLOT_IDX_W'(s));
    end else begin : g_data
      assign strobe_nx[s] = slot_end && (slot_nx == SLOT_IDX_W'(s))
                            && tag_q[TAG_BITS-1] && tag_q[TAG_BITS-1-s];
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      tag_q     <= '0;
      rx_word   <= '0;
      rx_slot   <= '0;
      rx_strobe <= '0;
    end else begin
      rx_strobe <= strobe_nx;
      if (locked) shreg <= shift_nx;
      if (slot_end) begin
        rx_slot <= slot_nx;
        if (slot_nx == '0) begin
          rx_word <= {{(SLOT_BITS-TAG_BITS){1'b0}}, shift_nx[TAG_BITS-1:0]};
          tag_q   <= shift_nx[TAG_BITS-1:0];
        end else begin
          rx_word <= shift_nx;
        end
      end
    end
  end
endmodule

// File: rtl/aclk_tx_ser.sv
module aclk_tx_ser
  import aclk_frame_pkg::*;
(
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic                  sync_edge,
  input  logic                  locked,
  input  pos_t                  bit_pos,
  input  logic                  codec_ready,
  input  logic [DATA_SLOTS-1:0] tx_slot_valid,
  input  logic [PAY_BITS-1:0]   tx_payload,
  output logic                  link_tx
);
  logic [FRAME_BITS-1:0] snap;
  logic [TAG_BITS-1:0]   tag_nx;
  logic [PAY_BITS-1:0]   pay_nx;
  pos_t                  drv_pos, drv_idx;

  always_comb begin
    tag_nx = '0;
    tag_nx[TAG_BITS-1] = codec_ready;
    for (int k = 0; k < DATA_SLOTS; k++) begin
      tag_nx[TAG_BITS-2-k] = tx_slot_valid[k];
      pay_nx[k*SLOT_BITS +: SLOT_BITS] =
        tx_slot_valid[k] ? tx_payload[k*SLOT_BITS +: SLOT_BITS] : '0;
    end
  end

  // Snapshot taken on the falling edge that detects sync.
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (sync_edge) snap <= pack_frame(tag_nx, pay_nx);
  end

  // The rising edge drives the position the next falling edge closes.
  assign drv_pos = pos_next(bit_pos);
  assign drv_idx = pos_t'(FRAME_BITS - 1) - drv_pos;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) link_tx <= 1'b0;
    else        link_tx <= locked ? snap[drv_idx] : 1'b0;
  end
endmodule

// File: rtl/aclk_frame_engine.sv
module aclk_frame_engine
  import aclk_frame_pkg::*;
(
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic                  frame_sync,
  input  logic                  link_rx,
  input  logic                  codec_ready,
  input  logic [DATA_SLOTS-1:0] tx_slot_valid,
  input  logic [PAY_BITS-1:0]   tx_payload,
  output logic                  link_tx,
  output logic [SLOT_BITS-1:0]  rx_word,
  output logic [SLOT_IDX_W-1:0] rx_slot,
  output logic [NUM_SLOTS-1:0]  rx_strobe,
  output logic                  frame_start,
  output logic                  frame_err
);
  pos_t cap_pos;
  pos_t bit_pos;
  logic sync_edge;
  logic misalign;
  logic locked;

  aclk_frame_timer u_timer (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .cap_pos     (cap_pos),
    .sync_edge   (sync_edge),
    .misalign    (misalign),
    .bit_pos     (bit_pos),
    .locked      (locked),
    .frame_start (frame_start),
    .frame_err   (frame_err)
  );

  aclk_rx_deser u_rx (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .link_rx   (link_rx),
    .locked    (locked),
    .misalign  (misalign),
    .cap_pos   (cap_pos),
    .rx_word   (rx_word),
    .rx_slot   (rx_slot),
    .rx_strobe (rx_strobe)
  );

  aclk_tx_ser u_tx (
    .bclk          (bclk),
    .rst_n         (rst_n),
    .sync_edge     (sync_edge),
    .locked        (locked),
    .bit_pos       (bit_pos),
    .codec_ready   (codec_ready),
    .tx_slot_valid (tx_slot_valid),
    .tx_payload    (tx_payload),
    .link_tx       (link_tx)
  );
endmodule

// File: rtl/aclk_frame_engine_chk.sv
module aclk_frame_engine_chk
  import aclk_frame_pkg::*;
(
  input logic                  bclk,
  input logic                  rst_n,
  input pos_t                  bit_pos,
  input logic                  locked,
  input logic                  frame_start,
  input logic                  frame_err,
  input logic [SLOT_IDX_W-1:0] rx_slot,
  input logic [NUM_SLOTS-1:0]  rx_strobe,
  input logic                  link_tx
);
  // R9
  strobe_onehot_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    $onehot0(rx_strobe));

  // R2
  start_pos_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    frame_start |-> (bit_pos == pos_t'(FRAME_BITS - 1)));

  // R2
  start_pulse_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R8
  err_with_start_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    frame_err |-> frame_start);

  // R4
  strobe_slot_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    (rx_strobe != '0) |-> (rx_strobe == (NUM_SLOTS'(1) << rx_slot)));

  // R4
  strobe_pos_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    (rx_strobe != '0) |-> (bit_pos == slot_end_pos(rx_slot)));

  // R1
  idle_rx_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    !locked |-> (rx_strobe == '0 && !frame_err));

  // R1
  idle_tx_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    !locked |-> !link_tx);
endmodule

bind aclk_frame_engine aclk_frame_engine_chk u_chk (
  .bclk        (bclk),
  .rst_n       (rst_n),
  .bit_pos     (bit_pos),
  .locked      (locked),
  .frame_start (frame_start),
  .frame_err   (frame_err),
  .rx_slot     (rx_slot),
  .rx_strobe   (rx_strobe),
  .link_tx     (link_tx)
);

// File: tb/aclk_frame_engine_test.sv
module aclk_frame_engine_test;
  localparam int CLK_PERIOD = 80;
  localparam int NB = 256;
  localparam int TB = 16;
  localparam int SB = 20;
  localparam int NS = 12;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic link_rx = 1'b0;
  logic codec_ready = 1'b0;
  logic [NS-1:0] tx_slot_valid = '0;
  logic [NS*SB-1:0] tx_payload = '0;

  logic link_tx;
  logic [SB-1:0] rx_word;
  logic [3:0] rx_slot;
  logic [NS:0] rx_strobe;
  logic frame_start, frame_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [TB-1:0] cur_tag = '0;
  logic [NS*SB-1:0] cur_pay = '0;
  bit tx_live = 0;

  aclk_frame_engine uut (
    .bclk(bclk), .rst_n(rst_n), .frame_sync(frame_sync), .link_rx(link_rx),
    .codec_ready(codec_ready), .tx_slot_valid(tx_slot_valid), .tx_payload(tx_payload),
    .link_tx(link_tx), .rx_word(rx_word), .rx_slot(rx_slot), .rx_strobe(rx_strobe),
    .frame_start(frame_start), .frame_err(frame_err));

  always #(CLK_PERIOD/2) bclk = ~bclk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bit p of a frame built from a tag and a payload.
  function automatic logic fbit(logic [TB-1:0] tag, logic [NS*SB-1:0] pay, int p);
    if (p < TB) return tag[TB-1-p];
    return pay[((p - TB) / SB) * SB + (SB - 1) - ((p - TB) % SB)];
  endfunction

  function automatic logic [NS*SB-1:0] rand_pay();
    logic [NS*SB-1:0] v;
    for (int k = 0; k < NS; k++) v[k*SB +: SB] = SB'($urandom);
    return v;
  endfunction

  // Expected outgoing tag and payload from the current tx inputs.
  task automatic take_snapshot();
    cur_tag = '0;
    cur_tag[15] = codec_ready;
    for (int k = 0; k < NS; k++) begin
      if (tx_slot_valid[k]) begin
        cur_tag[14-k] = 1'b1;
        cur_pay[k*SB +: SB] = tx_payload[k*SB +: SB];
      end else begin
        cur_pay[k*SB +: SB] = '0;
      end
    end
    tx_live = 1;
  endtask

  task automatic drive_bit(input logic d, input logic s);
    @(posedge bclk);
    #5;
    link_rx = d;
    frame_sync = s;
    @(negedge bclk);
    #5;
  endtask

  // One frame; sync is raised again at position cut.
  task automatic run_frame(input logic [TB-1:0] tag, input logic [NS*SB-1:0] pay,
                           input int cut, input string name);
    int tx_bad = 0, strb_bad = 0, word_bad = 0, sync_bad = 0;
    for (int p = 0; p <= cut; p++) begin
      logic [NS:0] es;
      int si;
      logic [SB-1:0] ew;
      es = '0;
      si = -1;
      ew = '0;
      drive_bit(fbit(tag, pay, p), (p < 15) || (p == cut));
      if (link_tx !== (tx_live ? fbit(cur_tag, cur_pay, p) : 1'b0)) tx_bad++;
      if ((p == 15 || (p > 15 && (p - 15) % SB == 0)) && (p != cut || cut == NB - 1))
        si = (p - 15) / SB;
      if (si == 0) begin
        es[0] = 1'b1;
        ew = {4'h0, tag};
      end else if (si > 0 && tag[15] && tag[15-si]) begin
        es[si] = 1'b1;
        ew = pay[(si-1)*SB +: SB];
      end
      if (rx_strobe !== es) strb_bad++;
      if (es != '0 && (rx_word !== ew || rx_slot !== 4'(si))) word_bad++;
      if (frame_start !== (p == cut) || frame_err !== (p == cut && cut != NB - 1)) sync_bad++;
      if (p == cut) take_snapshot();
    end
    chk("R6/R7", {name, " outgoing bits"}, tx_bad, 0);
    chk("R4 R5 R9", {name, " strobes"}, strb_bad, 0);
    chk("R3", {name, " slot words"}, word_bad, 0);
    chk(cut == NB - 1 ? "R2" : "R8", {name, " sync flags"}, sync_bad, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(posedge bclk);
    #5;
    chk("R1", "reset strobes", 32'(rx_strobe), 0);
    chk("R1", "reset link_tx/start/err", {29'd0, link_tx, frame_start, frame_err}, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_presync();
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      drive_bit(1'($urandom), 1'b0);
      if (rx_strobe !== '0 || link_tx !== 1'b0 || frame_start !== 1'b0 || frame_err !== 1'b0) bad++;
    end
    chk("R1", "activity before first sync", bad, 0);
    // First sync: captured bit closes a frame that was never seen.
    drive_bit(1'b0, 1'b1);
    chk("R2", "first sync start", {30'd0, frame_start, frame_err}, 32'h2);
    chk("R1", "no strobe at first sync", 32'(rx_strobe), 0);
    take_snapshot();
  endtask

  task automatic test_all_valid();
    logic [NS*SB-1:0] pay = rand_pay();
    run_frame(16'hFFF8, pay, NB - 1, "all-valid");
    run_frame(16'hFFFB, ~pay, NB - 1, "all-valid-inverted");
  endtask

  task automatic test_sparse();
    codec_ready = 1'b0;
    tx_slot_valid = 12'b0101_1010_0011;
    tx_payload = rand_pay();
    run_frame(16'b1_101010101010_0_10, rand_pay(), NB - 1, "sparse");
    run_frame(16'b1_010101010101_0_01, rand_pay(), NB - 1, "sparse-alt");
  endtask

  task automatic test_frame_invalid();
    codec_ready = 1'b1;
    tx_slot_valid = '0;
    tx_payload = {NS*SB{1'b1}};
    run_frame(16'h7FF8, rand_pay(), NB - 1, "frame-invalid");
    run_frame(16'h8000, rand_pay(), NB - 1, "no-slots");
  endtask

  task automatic test_misalign();
    tx_slot_valid = '1;
    tx_payload = rand_pay();
    // Early sync on the final bit of slot 4.
    run_frame(16'hFFF8, rand_pay(), 95, "misaligned");
    run_frame(16'hFFF8, rand_pay(), NB - 1, "after-resync");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    codec_ready = 1'b1;
    tx_slot_valid = '1;
    tx_payload = rand_pay();
    test_reset();
    test_presync();
    test_all_valid();
    test_sparse();
    test_frame_invalid();
    test_misalign();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule